// File: doc/BRIEF.md
# Expansion-Bus Memory Forwarding Decoder

This block lives in a bridge between a host bus and a slower expansion bus. It decides whether a host-bus memory cycle is handed to the expansion bus, and when. At the address phase it classifies the cycle address against everything the host side is known to hold. That includes main memory, which is a low range plus a relocatable high range. It also includes the video frame buffer window, which counts only when its enable is set, and four programmable regions.

An 8-bit control register selects the decode mode. In subtractive mode (the reset default), every memory cycle waits out a claim window. If no other agent asserts its claim (DEVSEL) within that window, the block pulses a forward strobe. In negative mode, a cycle that falls outside every known region is forwarded on the very next clock, without waiting. Cycles that hit a known region still go through the claim window. A flag next to the strobe tells an immediate forward apart from a timeout forward.

The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `mem_fwd_decoder`

## Requirements
- R1: After reset, the control register reads 00h, the block is in subtractive mode, and `fwd_pulse` and `fwd_immediate` are low.
- R2: A write with `ctrl_wr_en` high stores all 8 bits of `ctrl_wr_data`, and they read back on `ctrl_rd_data` from the next clock. Only bit 0 affects decoding (1 = negative mode, 0 = subtractive mode); bits 7:1 have no effect on forwarding.
- R3: In subtractive handling, the address phase is the rising edge that samples `cyc_start` high. If `claim_in` is low at all of edges 1 to 4 after it, `fwd_pulse` is high for exactly one clock following edge 4, with `fwd_immediate` low.
- R4: If `claim_in` is sampled high at any of edges 1 to 4 after the address phase, no forward is issued for that cycle. A claim at edge 5 or later does not stop the forward.
- R5: In negative mode, a cycle that hits no known region raises `fwd_pulse` and `fwd_immediate` together for one clock following the address-phase edge. No further strobe follows for that cycle.
- R6: In negative mode, a cycle that hits any known region (main memory, enabled video buffer, or a programmable region) gets the subtractive handling of R3 and R4.
- R7: The range 0A0000h to 0BFFFFh is a known region only while `vid_en` is 1. With `vid_en` at 0, it is unmapped.
- R8: Main memory covers the 64 KB pages below `mm_lo_top` (exclusive), plus pages `mm_hi_base` to `mm_hi_limit` inclusive. The high range is empty when its limit is below its base.
- R9: Programmable region i uses page fields [16i+15:16i] of `rgn_base` and `rgn_limit`. It covers pages base to limit inclusive, where the page is address bits 31:16. It is disabled when its limit is below its base.
- R10: A new address phase during an open claim window abandons the earlier cycle. Only the new cycle can produce a strobe.
- R11: `fwd_immediate` is never high without `fwd_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Control register write enable |
| ctrl_wr_data | input | 8 | Control register write data |
| ctrl_rd_data | output | 8 | Control register contents |
| mm_lo_top | input | 16 | First page above low main memory |
| mm_hi_base | input | 16 | First page of high main memory |
| mm_hi_limit | input | 16 | Last page of high main memory |
| vid_en | input | 1 | Video frame buffer window enable |
| rgn_base | input | 64 | Four programmable region base pages |
| rgn_limit | input | 64 | Four programmable region limit pages |
| cyc_start | input | 1 | Address phase of a memory cycle |
| cyc_addr | input | 32 | Memory cycle address |
| claim_in | input | 1 | Another agent claims the cycle (active high) |
| fwd_pulse | output | 1 | Forward the cycle to the expansion bus |
| fwd_immediate | output | 1 | Forward came from negative decode, not timeout |

## Verification
The bench sweeps every page of a small map in both modes and with the video enable both ways. Each cycle is given a claim at each edge of the window, at the first edge after it, or never. The sweep catches a window off by one edge, which would forward a claimed cycle or forward one clock early or late. It also catches inclusive limits handled as exclusive and disabled regions still matching. It catches a video window that counts when disabled, which would make an unmapped page wait out the timeout instead of forwarding at once. A restart test opens a second cycle in the middle of a window; a design that kept the old timer running would strobe at the first cycle's deadline. Writing the control register with bit 0 clear and every other bit set shows whether any bit besides bit 0 changes the mode.

// File: rtl/mfd_pkg.sv
`timescale 1ns/1ps
package mfd_pkg;
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_WAIT = 1'b1
  } tmr_state_e;

  typedef struct packed {
    logic pulse;
    logic immediate;
  } fwd_t;
endpackage

// File: rtl/mfd_ctrl_reg.sv
`timescale 1ns/1ps
module mfd_ctrl_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wr_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    q <= '0;
    else if (wr_en) q <= q_d;
  end
endmodule

// File: rtl/mfd_region_match.sv
`timescale 1ns/1ps
module mfd_region_match #(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 16,
  parameter int unsigned NREG      = 4,
  localparam int unsigned PW       = AW - GRAN_BITS
) (
  input  logic [AW-1:0]      addr,
  input  logic [PW-1:0]      mm_lo_top,
  input  logic [PW-1:0]      mm_hi_base,
  input  logic [PW-1:0]      mm_hi_limit,
  input  logic               vid_en,
  input  logic [NREG*PW-1:0] rgn_base,
  input  logic [NREG*PW-1:0] rgn_limit,
  output logic               hit_known
);
  localparam logic [AW-1:0] VID_LO = AW'(32'h000A_0000);
  localparam logic [AW-1:0] VID_HI = AW'(32'h000B_FFFF);

  logic [PW-1:0]   page;
  logic            hit_lo, hit_hi, hit_vid;
  logic [NREG-1:0] hit_rgn;

  assign page = addr[AW-1:GRAN_BITS];

  always_comb begin
    hit_lo  = page < mm_lo_top;
    hit_hi  = (page >= mm_hi_base) && (page <= mm_hi_limit);
    hit_vid = vid_en && (addr >= VID_LO) && (addr <= VID_HI);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_rgn
    logic [PW-1:0] base_i, lim_i;
    assign base_i     = rgn_base[i*PW +: PW];
    assign lim_i      = rgn_limit[i*PW +: PW];
    assign hit_rgn[i] = (page >= base_i) && (page <= lim_i);
  end

  assign hit_known = hit_lo || hit_hi || hit_vid || (|hit_rgn);
endmodule

// File: rtl/mfd_claim_timer.sv
`timescale 1ns/1ps
module mfd_claim_timer
  import mfd_pkg::*;
#(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned CW    = $clog2(WINDOW + 1)
) (
  input  logic clk,
  input  logic srst_n,
  input  logic restart,
  input  logic start_wait,
  input  logic claim,
  output logic fire
);
  tmr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    cnt_en = restart || (st_q == TMR_WAIT);
    if (restart) begin
      st_d  = start_wait ? TMR_WAIT : TMR_IDLE;
      cnt_d = CW'(1);
    end else if (st_q == TMR_WAIT) begin
      if (claim) begin
        st_d = TMR_IDLE;
      end else if (cnt_q == CW'(WINDOW)) begin
        fire = 1'b1;
        st_d = TMR_IDLE;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= TMR_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mem_fwd_decoder.sv
`timescale 1ns/1ps
module mem_fwd_decoder
  import mfd_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 16,
  parameter int unsigned NREG      = 4,
  parameter int unsigned WINDOW    = 4,
  parameter int unsigned CDW       = 8,
  localparam int unsigned PW       = AW - GRAN_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_en,
  input  logic [CDW-1:0]     ctrl_wr_data,
  output logic [CDW-1:0]     ctrl_rd_data,
  input  logic [PW-1:0]      mm_lo_top,
  input  logic [PW-1:0]      mm_hi_base,
  input  logic [PW-1:0]      mm_hi_limit,
  input  logic               vid_en,
  input  logic [NREG*PW-1:0] rgn_base,
  input  logic [NREG*PW-1:0] rgn_limit,
  input  logic               cyc_start,
  input  logic [AW-1:0]      cyc_addr,
  input  logic               claim_in,
  output logic               fwd_pulse,
  output logic               fwd_immediate
);
  logic rst_meta_q, rst_sync_q, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign srst_n = rst_sync_q;

  logic [CDW-1:0] ctrl_q;
  logic           neg_mode;

  mfd_ctrl_reg #(.DW(CDW)) u_ctrl (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (ctrl_wr_en),
    .wr_data (ctrl_wr_data),
    .q       (ctrl_q)
  );
  assign ctrl_rd_data = ctrl_q;
  assign neg_mode     = ctrl_q[0];

  logic hit_known;

  mfd_region_match #(.AW(AW), .GRAN_BITS(GRAN_BITS), .NREG(NREG)) u_match (
    .addr        (cyc_addr),
    .mm_lo_top   (mm_lo_top),
    .mm_hi_base  (mm_hi_base),
    .mm_hi_limit (mm_hi_limit),
    .vid_en      (vid_en),
    .rgn_base    (rgn_base),
    .rgn_limit   (rgn_limit),
    .hit_known   (hit_known)
  );

  logic imm_now, wait_now, tmo_fire;

  always_comb begin
    imm_now  = cyc_start && neg_mode && !hit_known;
    wait_now = cyc_start && !imm_now;
  end

  mfd_claim_timer #(.WINDOW(WINDOW)) u_timer (
    .clk        (clk),
    .srst_n     (srst_n),
    .restart    (cyc_start),
    .start_wait (wait_now),
    .claim      (claim_in),
    .fire       (tmo_fire)
  );

  fwd_t fwd_d, fwd_q;

  always_comb begin
    fwd_d.pulse     = imm_now || tmo_fire;
    fwd_d.immediate = imm_now;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) fwd_q <= '0;
    else         fwd_q <= fwd_d;
  end

  assign fwd_pulse     = fwd_q.pulse;
  assign fwd_immediate = fwd_q.immediate;
endmodule

// File: rtl/mfd_checker.sv
`timescale 1ns/1ps
module mfd_checker #(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned SW    = $clog2(WINDOW + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic claim_in,
  input logic neg_mode,
  input logic fwd_pulse,
  input logic fwd_immediate
);
  logic [SW-1:0] since_q;
  logic          seen_claim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q      <= SW'(WINDOW + 1);
      seen_claim_q <= 1'b0;
    end else if (cyc_start) begin
      since_q      <= '0;
      seen_claim_q <= 1'b0;
    end else begin
      if (since_q != SW'(WINDOW + 1)) since_q <= since_q + SW'(1);
      if (claim_in) seen_claim_q <= 1'b1;
    end
  end

  assert_imm_implies_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_immediate |-> fwd_pulse);

  assert_imm_after_neg_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_immediate |-> ($past(cyc_start) && $past(neg_mode)));

  assert_timeout_at_window_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_pulse && !fwd_immediate) |-> (since_q == SW'(WINDOW)));

  assert_claim_blocks_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_pulse && !fwd_immediate) |-> !seen_claim_q);

  assert_no_stale_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_pulse && !fwd_immediate) |-> !$past(cyc_start));
endmodule

bind mem_fwd_decoder mfd_checker #(.WINDOW(WINDOW)) u_mfd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_start     (cyc_start),
  .claim_in      (claim_in),
  .neg_mode      (ctrl_rd_data[0]),
  .fwd_pulse     (fwd_pulse),
  .fwd_immediate (fwd_immediate)
);

// File: tb/mem_fwd_decoder_test.sv
`timescale 1ns/1ps
module mem_fwd_decoder_test;
  logic        clk;
  logic        rst_n;
  logic        ctrl_wr_en;
  logic [7:0]  ctrl_wr_data;
  logic [7:0]  ctrl_rd_data;
  logic [15:0] mm_lo_top, mm_hi_base, mm_hi_limit;
  logic        vid_en;
  logic [63:0] rgn_base, rgn_limit;
  logic        cyc_start;
  logic [31:0] cyc_addr;
  logic        claim_in;
  logic        fwd_pulse, fwd_immediate;

  int unsigned nvec  = 0;
  int unsigned nfail = 0;
  bit          done  = 0;

  mem_fwd_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
    .mm_lo_top(mm_lo_top), .mm_hi_base(mm_hi_base), .mm_hi_limit(mm_hi_limit),
    .vid_en(vid_en), .rgn_base(rgn_base), .rgn_limit(rgn_limit),
    .cyc_start(cyc_start), .cyc_addr(cyc_addr), .claim_in(claim_in),
    .fwd_pulse(fwd_pulse), .fwd_immediate(fwd_immediate)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Map: low memory pages 0..1, high memory 14..14, regions 3..4, 6..6, disabled (9>8), 13..13
  localparam logic [15:0] LO_TOP = 16'd2;
  localparam logic [15:0] HI_B   = 16'd14;
  localparam logic [15:0] HI_L   = 16'd14;
  localparam logic [15:0] RB [4] = '{16'd3, 16'd6, 16'd9, 16'd13};
  localparam logic [15:0] RL [4] = '{16'd4, 16'd6, 16'd8, 16'd13};

  function automatic bit known(input int page, input bit ven);
    bit k;
    k = (page < int'(LO_TOP)) || (page >= int'(HI_B) && page <= int'(HI_L));
    if (ven && (page == 10 || page == 11)) k = 1;
    for (int i = 0; i < 4; i++)
      if (int'(RB[i]) <= int'(RL[i]) && page >= int'(RB[i]) && page <= int'(RL[i])) k = 1;
    return k;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = v;
    @(negedge clk); ctrl_wr_en = 1'b0;
    chk("R2 readback", ctrl_rd_data, v);
  endtask

  // claim_at: 0 none, k = claim at edge k after the address phase
  task automatic run_cycle(input string req, input logic [31:0] addr, input bit imm, input int claim_at);
    bit fwd_tmo;
    fwd_tmo = !imm && (claim_at == 0 || claim_at > 4);
    @(negedge clk); cyc_start = 1'b1; cyc_addr = addr; claim_in = 1'b0;
    @(negedge clk); cyc_start = 1'b0;
    for (int k = 0; k <= 5; k++) begin
      logic exp_p, exp_i;
      exp_p = (imm && k == 0) || (fwd_tmo && k == 4);
      exp_i = imm && k == 0;
      chk(req, {6'd0, fwd_pulse, fwd_immediate}, {6'd0, exp_p, exp_i});
      claim_in = (claim_at == k + 1);
      @(negedge clk);
    end
    claim_in = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
    mm_lo_top = LO_TOP; mm_hi_base = HI_B; mm_hi_limit = HI_L; vid_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rgn_base[i*16 +: 16]  = RB[i];
      rgn_limit[i*16 +: 16] = RL[i];
    end
    cyc_start = 1'b0; cyc_addr = '0; claim_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, subtractive by default
    chk("R1 ctrl reset", ctrl_rd_data, 8'h00);
    chk("R1 outputs idle", {6'd0, fwd_pulse, fwd_immediate}, 8'h00);
    run_cycle("R1 default subtractive", 32'h0005_0000, 1'b0, 0);

    // Sweep: mode x video enable x page x claim timing
    for (int m = 0; m < 2; m++) begin
      wr_ctrl(m == 1 ? 8'h01 : 8'hFE);  // R2: bits 7:1 set but mode stays subtractive
      for (int v = 0; v < 2; v++) begin
        vid_en = v[0];
        for (int p = 0; p < 16; p++) begin
          for (int c = 0; c <= 5; c++) begin
            bit imm;
            string req;
            imm = (m == 1) && !known(p, v[0]);
            if (p == 10 || p == 11)      req = "R7 video window";
            else if (p < 2 || p == 14)   req = "R8 main memory";
            else if (p == 8 || p == 9 || p == 3 || p == 4 || p == 6 || p == 13) req = "R9 region bounds";
            else if (m == 1)             req = "R5 negative miss";
            else                         req = "R3 subtractive";
            if (m == 1 && !imm) req = {req, " R6"};
            if (c > 0 && !imm)  req = {req, " R4"};
            run_cycle(req, {p[15:0], 16'(p * 4099)}, imm, c);
          end
        end
      end
    end

    // R7 edge addresses with video disabled/enabled in negative mode
    vid_en = 1'b0;
    run_cycle("R7 last video byte off", 32'h000B_FFFF, 1'b1, 0);
    vid_en = 1'b1;
    run_cycle("R7 last video byte on", 32'h000B_FFFF, 1'b0, 0);
    run_cycle("R7 byte above video", 32'h000C_0000, 1'b1, 0);

    // R10: restart mid-window in subtractive mode
    wr_ctrl(8'h00);
    @(negedge clk); cyc_start = 1'b1; cyc_addr = 32'h0005_0000;
    @(negedge clk); cyc_start = 1'b0;
    @(negedge clk);
    chk("R10 first cycle quiet", {6'd0, fwd_pulse, fwd_immediate}, 8'h00);
    cyc_start = 1'b1; cyc_addr = 32'h0007_0000;
    @(negedge clk); cyc_start = 1'b0;
    for (int k = 0; k <= 5; k++) begin
      chk("R10 restart", {6'd0, fwd_pulse, fwd_immediate}, {6'd0, (k == 4), 1'b0});
      @(negedge clk);
    end

    // R2: other control bits do not select negative mode
    wr_ctrl(8'hA4);
    run_cycle("R2 bits 7:1 no effect", 32'h0005_0000, 1'b0, 0);
    wr_ctrl(8'hA5);
    run_cycle("R2 bit0 negative", 32'h0005_0000, 1'b1, 0);
    run_cycle("R11 immediate only with pulse", 32'h0007_0000, 1'b1, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule